// File: doc/BRIEF.md
# USB Line-State Event Monitor

This block watches a USB segment without driving it. It receives the two single-ended data lines, a flag that gives the current bus speed, and a free-running reference tick of about one microsecond. From these it reports bus-level events to a capture interface. Line samples are taken once per bit time of the current speed, either full speed (12 Mbit/s) or low speed (1.5 Mbit/s). The classifier maps each sample onto SE0, J, K or the illegal both-high state. The meaning of J and K swaps with the speed flag.

The block reports each event as a single-cycle strobe that carries a 3-bit code. A long reset produces two entries, one when it starts and one when it ends. This keeps capture memory small and still shows the reset's duration. When an SE0 lasting two or more samples ends, the sample that follows it is examined. The block then decides whether that SE0 was a clean end of packet, the end of resume signalling, a low-speed keep-alive or a possible bad end of packet. An idle J that lasts for the suspend interval is reported once. The current classified line state is also available as an output.

Top module: `usb_line_monitor`

## Requirements
- R1: Lines are sampled once every FS_DIV clocks when `low_speed` is 0 and once every LS_DIV clocks when it is 1, and the divider restarts when the speed changes. `line_state` gives the last sample as 0 = SE0 (both low), 1 = J, 2 = K, 3 = both high. J is dp=1/dm=0 at full speed and dp=0/dm=1 at low speed.
- R2: `evt_valid` is high for exactly one clock per event, and `evt_code` is then one of: 1 reset start, 2 reset end, 3 resume end, 4 possible bad EOP, 5 keep-alive, 6 suspend. No event is reported after reset while the line stays J for less than the suspend interval.
- R3: An SE0 that stays sampled across RESET_TICKS reference ticks gives exactly one reset-start event (code 1).
- R4: When an SE0 that produced a reset start ends, one reset-end event (code 2) is emitted. The end of that SE0 never produces a resume-end, bad-EOP or keep-alive event, whatever state follows.
- R5: An SE0 of two or more samples that is followed by a sample other than J produces a possible-bad-EOP event (code 4). This includes a stray SE0 on an idle line.
- R6: An SE0 seen in only one sample produces no event.
- R7: A K run of at least RESUME_K_SAMPLES samples, directly followed by an SE0 of two or more samples and then J, produces a resume-end event (code 3).
- R8: At low speed, an SE0 of 2 to KA_MAX_SAMPLES samples that is followed by J, with no K sampled since the previous SE0 ended, produces a keep-alive event (code 5). The same pattern at full speed, or a longer SE0, produces none.
- R9: A packet, meaning K activity followed by an SE0 of two or more samples and then J, produces no event.
- R10: A J held across SUSPEND_TICKS reference ticks produces one suspend event (code 6). A shorter idle period, or continued idle after the event, produces nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp | input | 1 | D+ line level |
| dm | input | 1 | D- line level |
| low_speed | input | 1 | 1 = bus at 1.5 Mbit/s, 0 = 12 Mbit/s |
| ref_tick | input | 1 | One-clock pulse at the reference period (about 1 us) |
| evt_valid | output | 1 | Event strobe, one clock per event |
| evt_code | output | 3 | Event code, valid with `evt_valid` |
| line_state | output | 2 | Last classified line sample |

## Verification
Three conditions are hard to reach from the ports. The first is a low-speed keep-alive, because it needs an SE0 exit at low speed with no K sampled since the previous SE0. The second is a resume end, because it needs a long, unbroken K run. The third is a reset that ends in K, where every exit classifier has to stay silent. To reach them, the bench drives whole bit times at the current speed and switches speed between scenarios while the line is idle. It runs a line model alongside the stimulus that records K runs, K activity since the last SE0 and SE0 length. That model predicts the event list for both the directed cases and randomly mixed packets, glitches, resumes and resets. SE0 and idle lengths are kept well away from the tick thresholds, so every prediction is exact.

// File: rtl/usb_lsm_pkg.sv
package usb_lsm_pkg;

   typedef enum logic [1:0] {
      LS_SE0 = 2'd0,
      LS_J   = 2'd1,
      LS_K   = 2'd2,
      LS_SE1 = 2'd3
   } line_t;

   typedef enum logic [2:0] {
      EV_NONE        = 3'd0,
      EV_RESET_START = 3'd1,
      EV_RESET_END   = 3'd2,
      EV_RESUME_END  = 3'd3,
      EV_BAD_EOP     = 3'd4,
      EV_KEEP_ALIVE  = 3'd5,
      EV_SUSPEND     = 3'd6
   } evt_t;

   // Map a line pair onto a bus state; J/K polarity depends on speed.
   function automatic line_t classify(input logic dp, input logic dm, input logic low);
      line_t r;
      case ({dp, dm})
         2'b00:   r = LS_SE0;
         2'b11:   r = LS_SE1;
         2'b10:   r = low ? LS_K : LS_J;
         default: r = low ? LS_J : LS_K;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/usb_lsm_sampler.sv
module usb_lsm_sampler
   import usb_lsm_pkg::*;
#(
   parameter int FS_DIV      = 4,
   parameter int LS_DIV      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  dp,
   input  logic  dm,
   input  logic  low_speed,
   output logic  strobe,
   output line_t now_ls,
   output line_t cur_ls,
   output logic  spd_low
);

   localparam int CW = (LS_DIV > 1) ? $clog2(LS_DIV) : 1;
   localparam logic [CW-1:0] FS_LAST = CW'(FS_DIV - 1);
   localparam logic [CW-1:0] LS_LAST = CW'(LS_DIV - 1);
   // Reset image of the synchroniser: full-speed J.
   localparam logic [2:0] SYNC_RST = 3'b100;

   logic [2:0]    raw;
   logic [2:0]    syn;
   logic          spd_q;
   logic          restart;
   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign raw = {dp, dm, low_speed};

   // Line pair and speed travel through the same chain so they stay aligned.
   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign syn = raw;
      end else begin : g_sync
         logic [2:0] stg [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stg[i] <= SYNC_RST;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < SYNC_STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign syn = stg[SYNC_STAGES-1];
      end
   endgenerate

   assign spd_low = syn[0];
   assign restart = (spd_low != spd_q);
   assign last    = spd_low ? LS_LAST : FS_LAST;
   assign strobe  = !restart && (cnt == last);
   assign now_ls  = classify(syn[2], syn[1], syn[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spd_q <= 1'b0;
         cnt   <= '0;
      end else begin
         spd_q <= spd_low;
         if (restart || cnt == last) cnt <= '0;
         else                        cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cur_ls <= LS_J;
      else if (strobe) cur_ls <= now_ls;
   end

endmodule

// File: rtl/usb_lsm_hold_timer.sv
module usb_lsm_hold_timer #(
   parameter int LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic active,
   output logic hit,
   output logic fired
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   // One pulse when the condition has spanned LIMIT ticks; then silent.
   assign hit = active && tick && !fired && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (!active) begin
         cnt   <= '0;
         fired <= 1'b0;
      end else if (tick && !fired) begin
         if (cnt == LAST) fired <= 1'b1;
         else             cnt   <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/usb_lsm_se0_seq.sv
module usb_lsm_se0_seq
   import usb_lsm_pkg::*;
#(
   parameter int KA_MAX   = 3,
   parameter int RESUME_K = 16
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  strobe,
   input  line_t now_ls,
   input  line_t cur_ls,
   input  logic  low,
   input  logic  reset_fired,
   output evt_t  exit_evt
);

   localparam int SW = $clog2(KA_MAX + 2);
   localparam int KW = $clog2(RESUME_K + 1);
   localparam logic [SW-1:0] SE0_SAT = SW'(KA_MAX + 1);
   localparam logic [SW-1:0] SE0_MIN = SW'(2);
   localparam logic [SW-1:0] KA_TOP  = SW'(KA_MAX);
   localparam logic [KW-1:0] K_SAT   = KW'(RESUME_K);

   logic [SW-1:0] se0_run;
   logic [KW-1:0] k_run;
   logic          resume_arm;
   logic          traffic;
   logic          se0_exit;

   assign se0_exit = strobe && (cur_ls == LS_SE0) && (now_ls != LS_SE0);

   always_comb begin
      exit_evt = EV_NONE;
      if (se0_exit) begin
         if (reset_fired)               exit_evt = EV_RESET_END;
         else if (se0_run >= SE0_MIN) begin
            if (now_ls != LS_J)         exit_evt = EV_BAD_EOP;
            else if (resume_arm)        exit_evt = EV_RESUME_END;
            else if (low && !traffic && se0_run <= KA_TOP)
                                        exit_evt = EV_KEEP_ALIVE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         se0_run    <= '0;
         k_run      <= '0;
         resume_arm <= 1'b0;
         traffic    <= 1'b0;
      end else if (strobe) begin
         if (now_ls == LS_SE0) begin
            k_run <= '0;
            if (cur_ls != LS_SE0) begin
               se0_run    <= SW'(1);
               resume_arm <= (cur_ls == LS_K) && (k_run == K_SAT);
            end else if (se0_run != SE0_SAT) begin
               se0_run <= se0_run + 1'b1;
            end
         end else begin
            se0_run <= '0;
            if (now_ls == LS_K) begin
               if (k_run != K_SAT) k_run <= k_run + 1'b1;
            end else begin
               k_run <= '0;
            end
            if (cur_ls == LS_SE0) begin
               resume_arm <= 1'b0;
               traffic    <= (now_ls == LS_K);
            end else if (now_ls == LS_K) begin
               traffic <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/usb_line_monitor.sv
module usb_line_monitor
   import usb_lsm_pkg::*;
#(
   parameter int FS_DIV           = 4,
   parameter int LS_DIV           = 32,
   parameter int SYNC_STAGES      = 2,
   parameter int RESET_TICKS      = 3,
   parameter int SUSPEND_TICKS    = 3000,
   parameter int KA_MAX_SAMPLES   = 3,
   parameter int RESUME_K_SAMPLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dp,
   input  logic       dm,
   input  logic       low_speed,
   input  logic       ref_tick,
   output logic       evt_valid,
   output logic [2:0] evt_code,
   output logic [1:0] line_state
);

   generate
      if (FS_DIV < 2)                     begin : g_bad_fs  $error("FS_DIV must be at least 2");           end
      if (LS_DIV <= FS_DIV)               begin : g_bad_ls  $error("LS_DIV must exceed FS_DIV");            end
      if (SYNC_STAGES < 0)                begin : g_bad_syn $error("SYNC_STAGES must not be negative");     end
      if (RESET_TICKS < 1)                begin : g_bad_rst $error("RESET_TICKS must be at least 1");       end
      if (SUSPEND_TICKS <= RESET_TICKS)   begin : g_bad_sus $error("SUSPEND_TICKS must exceed RESET_TICKS"); end
      if (KA_MAX_SAMPLES < 2)             begin : g_bad_ka  $error("KA_MAX_SAMPLES must be at least 2");    end
      if (RESUME_K_SAMPLES < 2)           begin : g_bad_rk  $error("RESUME_K_SAMPLES must be at least 2");  end
   endgenerate

   logic  strobe;
   line_t now_ls;
   line_t cur_ls;
   logic  spd_low;
   logic  leaving;
   logic  rst_active;
   logic  rst_hit;
   logic  rst_fired;
   logic  sus_active;
   logic  sus_hit;
   logic  sus_fired;
   evt_t  exit_evt;
   evt_t  evt_d;
   evt_t  evt_q;

   usb_lsm_sampler #(
      .FS_DIV      (FS_DIV),
      .LS_DIV      (LS_DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_sampler (
      .clk       (clk),
      .rst_n     (rst_n),
      .dp        (dp),
      .dm        (dm),
      .low_speed (low_speed),
      .strobe    (strobe),
      .now_ls    (now_ls),
      .cur_ls    (cur_ls),
      .spd_low   (spd_low)
   );

   // A state that ends on this strobe no longer counts toward its timer.
   assign leaving    = strobe && (now_ls != cur_ls);
   assign rst_active = (cur_ls == LS_SE0) && !leaving;
   assign sus_active = (cur_ls == LS_J)   && !leaving;

   usb_lsm_hold_timer #(.LIMIT(RESET_TICKS)) i_reset_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (ref_tick),
      .active (rst_active),
      .hit    (rst_hit),
      .fired  (rst_fired)
   );

   usb_lsm_hold_timer #(.LIMIT(SUSPEND_TICKS)) i_suspend_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (ref_tick),
      .active (sus_active),
      .hit    (sus_hit),
      .fired  (sus_fired)
   );

   usb_lsm_se0_seq #(
      .KA_MAX   (KA_MAX_SAMPLES),
      .RESUME_K (RESUME_K_SAMPLES)
   ) i_se0_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .strobe      (strobe),
      .now_ls      (now_ls),
      .cur_ls      (cur_ls),
      .low         (spd_low),
      .reset_fired (rst_fired),
      .exit_evt    (exit_evt)
   );

   // Sources are mutually exclusive by line state; order is a safeguard.
   always_comb begin
      if (exit_evt != EV_NONE) evt_d = exit_evt;
      else if (rst_hit)        evt_d = EV_RESET_START;
      else if (sus_hit)        evt_d = EV_SUSPEND;
      else                     evt_d = EV_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= EV_NONE;
      else        evt_q <= evt_d;
   end

   assign evt_valid  = (evt_q != EV_NONE);
   assign evt_code   = evt_q;
   assign line_state = cur_ls;

endmodule

// File: rtl/usb_line_monitor_chk.sv
module usb_line_monitor_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       evt_valid,
   input logic [2:0] evt_code,
   input logic [1:0] line_state,
   input logic       speed_low
);

   logic in_reset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              in_reset <= 1'b0;
      else if (evt_valid && evt_code == 3'd1)  in_reset <= 1'b1;
      else if (evt_valid && evt_code == 3'd2)  in_reset <= 1'b0;
   end

   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> (evt_code >= 3'd1 && evt_code <= 3'd6)); // R2

   AST_RESET_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd1) |-> !in_reset); // R3

   AST_RESET_END_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd2) |-> in_reset); // R4

   AST_RESET_EXIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      in_reset |-> !(evt_valid && (evt_code == 3'd3 || evt_code == 3'd4 || evt_code == 3'd5))); // R4

   AST_KEEPALIVE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd5) |-> $past(speed_low)); // R8

   AST_SUSPEND_ON_J: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd6) |-> $past(line_state) == 2'd1); // R10

   AST_SUSPEND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && evt_code == 3'd6) |=> !(evt_valid && evt_code == 3'd6)); // R10

endmodule

bind usb_line_monitor usb_line_monitor_chk i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_valid  (evt_valid),
   .evt_code   (evt_code),
   .line_state (line_state),
   .speed_low  (spd_low)
);

// File: tb/test_usb_line_monitor.sv
module test_usb_line_monitor;

   localparam int FSD   = 4;
   localparam int LSD   = 32;
   localparam int TICKP = 64;
   localparam int ST_SE0 = 0, ST_J = 1, ST_K = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dp = 1'b1;
   logic       dm = 1'b0;
   logic       low_speed = 1'b0;
   logic       ref_tick = 1'b0;
   logic       evt_valid;
   logic [2:0] evt_code;
   logic [1:0] line_state;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int got_q[$];
   int exp_q[$];

   // line model
   int prev_st = ST_J;
   int krun = 0;
   int se0_bits = 0;
   bit traffic = 0;
   bit resume_arm = 0;

   usb_line_monitor #(
      .FS_DIV(FSD), .LS_DIV(LSD), .SYNC_STAGES(2), .RESET_TICKS(3),
      .SUSPEND_TICKS(30), .KA_MAX_SAMPLES(3), .RESUME_K_SAMPLES(16)
   ) i_usb_line_monitor (
      .clk(clk), .rst_n(rst_n), .dp(dp), .dm(dm), .low_speed(low_speed),
      .ref_tick(ref_tick), .evt_valid(evt_valid), .evt_code(evt_code),
      .line_state(line_state)
   );

   always #4 clk = ~clk;

   int tcnt = 0;
   always @(posedge clk) begin
      tcnt     <= (tcnt == TICKP - 1) ? 0 : tcnt + 1;
      ref_tick <= (tcnt == TICKP - 1);
   end

   always @(negedge clk) if (rst_n && evt_valid) got_q.push_back(int'(evt_code));

   function automatic int divn();
      return low_speed ? LSD : FSD;
   endfunction

   // Expected event at the end of an SE0, from the requirements.
   function automatic void model_exit(input int nxt);
      if (se0_bits * divn() >= 256) begin
         exp_q.push_back(1); exp_q.push_back(2);          // R3 R4
      end else if (se0_bits >= 2) begin
         if (nxt != ST_J)                exp_q.push_back(4); // R5
         else if (resume_arm)            exp_q.push_back(3); // R7
         else if (low_speed && !traffic && se0_bits <= 3)
                                         exp_q.push_back(5); // R8
      end
   endfunction

   task automatic put(input int st, input int n);
      @(negedge clk);
      case (st)
         ST_SE0:  begin dp = 1'b0; dm = 1'b0; end
         ST_J:    begin dp = !low_speed; dm = low_speed; end
         default: begin dp = low_speed; dm = !low_speed; end
      endcase
      if (st == ST_SE0) begin
         if (prev_st != ST_SE0) begin
            se0_bits   = n;
            resume_arm = (prev_st == ST_K) && (krun >= 16);
         end else se0_bits += n;
         krun = 0;
      end else begin
         if (prev_st == ST_SE0) begin
            model_exit(st);
            traffic    = (st == ST_K);
            resume_arm = 0;
         end
         if (st == ST_K) begin
            krun    = (prev_st == ST_K) ? krun + n : n;
            traffic = 1;
         end else krun = 0;
      end
      prev_st = st;
      repeat (n * divn() - 1) @(negedge clk);
   endtask

   task automatic set_speed(input bit l);
      @(negedge clk);
      low_speed = l;
      put(ST_J, 4);
   endtask

   function automatic string fmt(input int q[$]);
      string s = "{";
      foreach (q[i]) s = {s, $sformatf(" %0d", q[i])};
      return {s, " }"};
   endfunction

   task automatic check_events(input string req);
      bit bad = 0;
      checks++;
      if (got_q.size() != exp_q.size()) bad = 1;
      else foreach (got_q[i]) if (got_q[i] != exp_q[i]) bad = 1;
      if (bad) begin
         errors++;
         $display("FAIL %s: events actual %s expected %s", req, fmt(got_q), fmt(exp_q));
      end
      got_q.delete();
      exp_q.delete();
   endtask

   task automatic check_line(input string req, input int exp);
      checks++;
      if (int'(line_state) != exp) begin
         errors++;
         $display("FAIL %s: line_state actual %0d expected %0d", req, line_state, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R2 reset state
      checks++;
      if (evt_valid !== 1'b0) begin
         errors++;
         $display("FAIL R2: evt_valid actual %0b expected 0", evt_valid);
      end
      check_line("R1 reset", ST_J);
      put(ST_J, 20);
      check_events("R2 idle after reset");

      // R1 classification and speed-dependent polarity
      put(ST_K, 3);   check_line("R1 FS K", ST_K);
      put(ST_J, 3);   check_line("R1 FS J", ST_J);
      put(ST_SE0, 3); check_line("R1 SE0", ST_SE0);
      put(ST_J, 4);
      set_speed(1);   check_line("R1 LS J", ST_J);
      @(negedge clk); dp = 1'b1; dm = 1'b0;
      repeat (2 * LSD) @(negedge clk);
      check_line("R1 LS dp-high is K", ST_K);
      prev_st = ST_K; krun = 2; traffic = 1;
      put(ST_J, 4);
      set_speed(0);
      check_events("R1 sequence");

      // R5 stray SE0 on idle line followed by K
      put(ST_SE0, 2); put(ST_K, 2); put(ST_J, 4);
      check_events("R5 idle SE0 then K");
      // R6 one-sample SE0
      put(ST_SE0, 1); put(ST_K, 2); put(ST_J, 4);
      check_events("R6 single SE0");
      // R7 resume end
      put(ST_K, 20); put(ST_SE0, 2); put(ST_J, 4);
      check_events("R7 resume end");
      // R9 packet EOP
      put(ST_K, 1); put(ST_J, 2); put(ST_K, 3); put(ST_SE0, 2); put(ST_J, 4);
      check_events("R9 packet EOP");

      // R8 keep-alive tolerance and speed dependence
      set_speed(1);
      put(ST_SE0, 2); put(ST_J, 4); check_events("R8 LS keep-alive 2");
      put(ST_SE0, 3); put(ST_J, 4); check_events("R8 LS keep-alive 3");
      put(ST_SE0, 4); put(ST_J, 4); check_events("R8 LS long SE0");
      set_speed(0);
      put(ST_SE0, 2); put(ST_J, 4); check_events("R8 FS no keep-alive");

      // R3 R4 reset at both speeds and both exits
      put(ST_SE0, 75); put(ST_J, 4); check_events("R3 R4 FS reset");
      put(ST_SE0, 75); put(ST_K, 2); put(ST_J, 4); check_events("R4 reset end to K");
      set_speed(1);
      put(ST_SE0, 10); put(ST_J, 4); check_events("R4 LS reset no keep-alive");
      set_speed(0);

      // R10 suspend
      put(ST_K, 1);
      put(ST_J, 320);
      check_events("R10 short idle");
      put(ST_K, 1);
      put(ST_J, 640);
      exp_q.push_back(6);
      check_events("R10 suspend");
      put(ST_J, 500);
      check_events("R10 no repeat");
      put(ST_K, 1); put(ST_J, 4);
      check_events("R10 rearm");

      // mixed random scenarios
      for (int it = 0; it < 40; it++) begin
         int kind;
         string tag;
         set_speed(bit'($urandom % 2));
         kind = int'($urandom % 4);
         case (kind)
            0: begin
               tag = "R9 random packet";
               put(ST_K, 1);
               for (int b = 0; b < 2 + int'($urandom % 7); b++)
                  put(($urandom % 2) ? ST_J : ST_K, 1 + int'($urandom % 3));
               put(ST_SE0, 2);
            end
            1: begin
               tag = "R5 R6 R8 random SE0";
               put(ST_SE0, 1 + int'($urandom % (low_speed ? 4 : 8)));
               put(($urandom % 2) ? ST_J : ST_K, 2);
            end
            2: begin
               tag = "R7 random resume";
               put(ST_K, 16 + int'($urandom % 8));
               put(ST_SE0, 2 + int'($urandom % 2));
               put(($urandom % 2) ? ST_J : ST_K, 2);
            end
            default: begin
               tag = "R3 R4 random reset";
               put(ST_SE0, low_speed ? 10 : 75);
               put(($urandom % 2) ? ST_J : ST_K, 2);
            end
         endcase
         put(ST_J, 4);
         check_events(tag);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule